// File: doc/BRIEF.md
# General-Purpose I/O Port with Blink and Input Polarity

This block is a 32-pin general-purpose I/O port with a small memory-mapped register slave. Software sets each pin's output level, chooses input or driven-output mode per pin, turns on a hardware blinker for selected output pins, and selects a per-pin input inversion. Pin inputs pass through a two-flop synchroniser. The synchronised, polarity-adjusted input vector can be read back through the bus and is also exported as a port for separate interrupt logic.

Two small state machines make up the control. The bus state machine has the states BUS_IDLE and BUS_RESP. The transition BUS_IDLE→BUS_RESP fires when `bus_sel` is high in BUS_IDLE; the access takes effect on that edge. The transition BUS_RESP→BUS_IDLE always fires on the next edge, and `bus_ack` is high only while the state is BUS_RESP. The blink phase state machine has the states PH_LOW and PH_HIGH. A free-running counter counts `HALF_CYCLES` clocks, and each time it wraps the phase moves PH_LOW→PH_HIGH or PH_HIGH→PH_LOW. The default count gives a 100 ms half-period at 250 MHz.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output-level, blink-enable and polarity registers read 0, the direction register reads all ones, `pin_oe` is 0 and `bus_ack` is 0.
- R2: A `bus_sel` pulse seen in the idle state produces `bus_ack` high for exactly one cycle after that edge. Read data is valid on `bus_rdata` while `bus_ack` is high, and `bus_sel` is ignored while `bus_ack` is high.
- R3: The registers sit at byte offsets 0x00 (output level), 0x04 (direction), 0x08 (blink enable) and 0x0C (polarity), and each reads back the last value written. Offset 0x10 is the read-only data-in register, and writes to it change no register.
- R4: For each pin, a direction bit of 1 makes it an input (`pin_oe` 0) and a direction bit of 0 makes it a driven output (`pin_oe` 1).
- R5: For a pin whose blink bit is 0, `pin_out` equals its output-level bit.
- R6: Data-in reads and the `in_adj` port both equal the synchronised pin level XOR the polarity register, bit by bit.
- R7: A change on `pin_in` is not yet visible on `in_adj` after the first clock edge and is visible after the second.
- R8: For a pin whose blink bit is 1, `pin_out` equals its output-level bit XOR the blink phase. The phase is 0 after reset and inverts every `HALF_CYCLES` clocks, so after the k-th edge since reset it equals (k / `HALF_CYCLES`) mod 2.
- R9: Every other offset, including the unaligned ones and 0x14–0x1F, reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ack |
| bus_ack | output | 1 | One-cycle access acknowledge |
| pin_in | input | 32 | Raw pin levels |
| pin_out | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output enables |
| in_adj | output | 32 | Synchronised, polarity-adjusted inputs |

## Verification
The bench counts clock edges from the release of reset and predicts the blink phase absolutely. A blinker that started high, wrapped one count early or late, or ignored the output-level bit would show up as wrong `pin_out` bits on blinking pins. Random writes that land on data-in and on unmapped or unaligned offsets would corrupt the register model if any decode were loose, and reads of those offsets must return zero. A directed pin change is sampled after one edge and after two, which catches a synchroniser with one flop or three, and random polarity masks catch an inversion applied on only one of the two paths.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int unsigned REG_ADDR_W = 5;

    localparam logic [REG_ADDR_W-1:0] OFF_LEVEL = 5'h00;
    localparam logic [REG_ADDR_W-1:0] OFF_DIR   = 5'h04;
    localparam logic [REG_ADDR_W-1:0] OFF_BLINK = 5'h08;
    localparam logic [REG_ADDR_W-1:0] OFF_POL   = 5'h0C;
    localparam logic [REG_ADDR_W-1:0] OFF_DIN   = 5'h10;

    typedef enum logic {BUS_IDLE, BUS_RESP} bus_state_e;
    typedef enum logic {PH_LOW, PH_HIGH} blink_phase_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_blink.sv
module gpio_blink
    import gpio_port_pkg::*;
#(
    parameter int unsigned HALF_CYCLES = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    output logic phase_o
);
    localparam int unsigned CNT_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    blink_phase_e     phase_q, phase_d;

    assign wrap = (cnt_q == CNT_LAST);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wrap) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            phase_q <= PH_LOW;
        end else begin
            phase_q <= phase_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW:  if (wrap) phase_d = PH_HIGH;
            PH_HIGH: if (wrap) phase_d = PH_LOW;
            default: phase_d = PH_LOW;
        endcase
    end

    assign phase_o = (phase_q == PH_HIGH);

    // R8: the phase moves only on the edge that closes a half-period
    a_r8_phase_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase_q != $past(phase_q)) |-> $past(wrap));

    // R8: the counter never passes the half-period limit
    a_r8_count_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST);
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned N_PINS = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sel_i,
    input  logic                  wr_i,
    input  logic [REG_ADDR_W-1:0] addr_i,
    input  logic [N_PINS-1:0]     wdata_i,
    input  logic [N_PINS-1:0]     din_i,
    output logic [N_PINS-1:0]     rdata_o,
    output logic                  ack_o,
    output logic [N_PINS-1:0]     level_o,
    output logic [N_PINS-1:0]     dir_o,
    output logic [N_PINS-1:0]     blink_o,
    output logic [N_PINS-1:0]     pol_o
);
    bus_state_e        state_q, state_d;
    logic              access;
    logic              mapped;
    logic [N_PINS-1:0] rd_mux;
    logic [N_PINS-1:0] level_q, dir_q, blink_q, pol_q, rdata_q;

    assign access = (state_q == BUS_IDLE) && sel_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (sel_i) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        mapped = 1'b1;
        rd_mux = '0;
        unique case (addr_i)
            OFF_LEVEL: rd_mux = level_q;
            OFF_DIR:   rd_mux = dir_q;
            OFF_BLINK: rd_mux = blink_q;
            OFF_POL:   rd_mux = pol_q;
            OFF_DIN:   rd_mux = din_i;
            default:   mapped = 1'b0;
        endcase
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            level_q <= '0;
            dir_q   <= '1;
            blink_q <= '0;
            pol_q   <= '0;
            rdata_q <= '0;
        end else if (access) begin
            rdata_q <= wr_i ? '0 : rd_mux;
            if (wr_i) begin
                if (addr_i == OFF_LEVEL) level_q <= wdata_i;
                if (addr_i == OFF_DIR)   dir_q   <= wdata_i;
                if (addr_i == OFF_BLINK) blink_q <= wdata_i;
                if (addr_i == OFF_POL)   pol_q   <= wdata_i;
            end
        end
    end

    assign ack_o   = (state_q == BUS_RESP);
    assign rdata_o = rdata_q;
    assign level_o = level_q;
    assign dir_o   = dir_q;
    assign blink_o = blink_q;
    assign pol_o   = pol_q;

    // R2: acknowledge lasts exactly one cycle
    a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
        ack_o |=> !ack_o);

    // R2: an accepted request is acknowledged on the next cycle
    a_r2_ack_follows: assert property (@(posedge clk) disable iff (rst)
        (!ack_o && sel_i) |=> ack_o);

    // R9: writes to unmapped offsets leave every register unchanged
    a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (access && wr_i && !mapped) |=>
        ($stable(level_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));

    // R3: the data-in offset is read-only
    a_r3_din_readonly: assert property (@(posedge clk) disable iff (rst)
        (access && wr_i && addr_i == OFF_DIN) |=>
        ($stable(level_q) && $stable(dir_q) && $stable(blink_q) && $stable(pol_q)));

    // R9: unmapped reads return zero
    a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
        (access && !wr_i && !mapped) |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int unsigned N_PINS      = 32,
    parameter int unsigned HALF_CYCLES = 25_000_000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [N_PINS-1:0]     bus_wdata,
    output logic [N_PINS-1:0]     bus_rdata,
    output logic                  bus_ack,
    input  logic [N_PINS-1:0]     pin_in,
    output logic [N_PINS-1:0]     pin_out,
    output logic [N_PINS-1:0]     pin_oe,
    output logic [N_PINS-1:0]     in_adj
);
    logic [N_PINS-1:0] level, dir, blink, pol, synced;
    logic              phase;

    gpio_sync #(.WIDTH(N_PINS)) u_sync (
        .clk(clk), .rst(rst), .raw_i(pin_in), .sync_o(synced)
    );

    gpio_blink #(.HALF_CYCLES(HALF_CYCLES)) u_blink (
        .clk(clk), .rst(rst), .phase_o(phase)
    );

    gpio_regs #(.N_PINS(N_PINS)) u_regs (
        .clk(clk), .rst(rst),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
        .din_i(in_adj), .rdata_o(bus_rdata), .ack_o(bus_ack),
        .level_o(level), .dir_o(dir), .blink_o(blink), .pol_o(pol)
    );

    assign in_adj = synced ^ pol;

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        assign pin_out[i] = level[i] ^ (blink[i] & phase);
        assign pin_oe[i]  = ~dir[i];

        // R5: a non-blinking pin holds its level unless the level register was written
        a_r5_steady: assert property (@(posedge clk) disable iff (rst)
            (!blink[i] && !$past(blink[i]) && $stable(level[i])) |-> $stable(pin_out[i]));
    end
endmodule

// File: tb/tb_gpio_port.sv
module tb_gpio_port;
    localparam int unsigned HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata, pin_in = '0, pin_out, pin_oe, in_adj;
    logic        bus_ack;

    int n_vec = 0, n_bad = 0, cyc = 0;
    logic [31:0] m_level = '0, m_dir = '1, m_blink = '0, m_pol = '0, m_pin = '0;

    gpio_port #(.N_PINS(32), .HALF_CYCLES(HALF)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .in_adj(in_adj)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            5'h00:   return m_level;
            5'h04:   return m_dir;
            5'h08:   return m_blink;
            5'h0C:   return m_pol;
            5'h10:   return m_pin ^ m_pol;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_out(input int k);
        logic ph;
        ph = ((k / HALF) % 2) == 1;
        return m_level ^ (m_blink & {32{ph}});
    endfunction

    // sampled at a falling edge: cyc equals the edges since reset release
    task automatic check_pins();
        chk(pin_out == exp_out(cyc), "R5/R8 pin_out", pin_out, exp_out(cyc));
        chk(pin_oe == ~m_dir, "R4 pin_oe", pin_oe, ~m_dir);
        chk(in_adj == (m_pin ^ m_pol), "R6 in_adj", in_adj, m_pin ^ m_pol);
    endtask

    task automatic bus(input bit wr, input logic [4:0] a, input logic [31:0] d);
        logic [31:0] e;
        @(negedge clk);
        chk(bus_ack == 1'b0, "R2 ack idle", {31'b0, bus_ack}, 32'h0);
        e = exp_read(a);
        bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        chk(bus_ack == 1'b1, "R2 ack", {31'b0, bus_ack}, 32'h1);
        if (!wr) chk(bus_rdata == e, (a > 5'h10 || a[1:0] != 0) ? "R9 read" : "R3/R6 read", bus_rdata, e);
        if (wr) begin
            case (a)
                5'h00: m_level = d;
                5'h04: m_dir = d;
                5'h08: m_blink = d;
                5'h0C: m_pol = d;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_sel = 1'b0;
        check_pins();
    endtask

    task automatic set_pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk); @(posedge clk);
        m_pin = v;
    endtask

    function automatic logic [4:0] pick_addr();
        int r = $urandom_range(0, 6);
        case (r)
            0: return 5'h00;
            1: return 5'h04;
            2: return 5'h08;
            3: return 5'h0C;
            4: return 5'h10;
            default: return 5'($urandom_range(0, 31));
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pin_oe == 32'h0, "R1 oe reset", pin_oe, 32'h0);
        chk(bus_ack == 1'b0, "R1 ack reset", {31'b0, bus_ack}, 32'h0);
        bus(1'b0, 5'h00, '0);
        bus(1'b0, 5'h04, '0);
        bus(1'b0, 5'h08, '0);
        bus(1'b0, 5'h0C, '0);

        // R7: two-edge synchroniser latency (polarity still 0)
        @(negedge clk);
        pin_in = 32'hA5A5_0F0F;
        @(posedge clk); #1;
        chk(in_adj == 32'h0, "R7 after one edge", in_adj, 32'h0);
        @(posedge clk); #1;
        chk(in_adj == 32'hA5A5_0F0F, "R7 after two edges", in_adj, 32'hA5A5_0F0F);
        m_pin = 32'hA5A5_0F0F;

        // R3/R4/R5/R8: directed writes, blink with both level values
        bus(1'b1, 5'h04, 32'hFFFF_0000);
        bus(1'b1, 5'h00, 32'h0000_00F0);
        bus(1'b1, 5'h08, 32'h0000_0FF0);
        repeat (3 * HALF) begin
            @(negedge clk);
            check_pins();
        end
        // R3: data-in is read-only; R9: unmapped and unaligned writes ignored
        bus(1'b1, 5'h10, 32'hDEAD_BEEF);
        bus(1'b1, 5'h14, 32'hDEAD_BEEF);
        bus(1'b1, 5'h02, 32'hDEAD_BEEF);
        bus(1'b1, 5'h1F, 32'hDEAD_BEEF);
        bus(1'b0, 5'h00, '0);
        bus(1'b0, 5'h04, '0);
        bus(1'b0, 5'h08, '0);
        bus(1'b0, 5'h0C, '0);
        bus(1'b0, 5'h18, '0);
        bus(1'b0, 5'h05, '0);
        // R6: polarity inversion
        bus(1'b1, 5'h0C, 32'hFF00_FF00);
        bus(1'b0, 5'h10, '0);

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op = $urandom_range(0, 3);
            if (op == 0)      bus(1'b1, pick_addr(), $urandom);
            else if (op == 1) bus(1'b0, pick_addr(), '0);
            else if (op == 2) set_pins($urandom);
            else begin
                @(negedge clk);
                check_pins();
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_vec++;
        n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule